// File: doc/BRIEF.md
# PCI ECAM Configuration Responder

This block models the configuration side of one single-function PCI endpoint as seen through an ECAM-style memory window. Every configuration access carries a 28-bit window offset. The block splits that offset into bus, device, function and register fields. It answers only when the target is bus 0, the slot set by a parameter, and function 0. Reads to any other target return all-ones, and writes to them are dropped.

The responder holds a type-0 header for a modern virtio-style block device. The header has a chain of four vendor-specific capabilities that point into BAR0. BAR0 is a 4 KiB 32-bit memory BAR. Writing all-ones to it is the usual way to probe its size. A second port watches accesses to the downstream MMIO window. It reports a hit and the offset into the BAR when the address falls inside the programmed BAR0 and memory decoding is enabled.

Configuration reads return data one cycle after the request. Window hits are also reported one cycle after the access.

Top module: `ecam_cfg_responder`

## Requirements
- R1: A configuration read answers with `cfg_rvalid` high in the next cycle, and a write never raises `cfg_rvalid`. The offset fields are:
  - bus = bits 27:20
  - device = bits 19:15
  - function = bits 14:12
  - register = bits 11:0

  Any target other than bus 0, device SLOT (default 1), function 0 reads 0xFFFFFFFF.
- R2: Writes to a non-matching target change no state of the endpoint.
- R3: Identity words read as fixed values:
  - dword 0x00 reads 0x10421AF4 (vendor 0x1AF4 in the low half, device 0x1042 in the high half)
  - dword 0x08 reads 0x01800001
  - dword 0x0C reads 0, so the header type is 0
  - dword 0x2C reads 0x00021AF4
- R4: The status half of dword 0x04 reads 0x0010, which is the capabilities-list bit. Dword 0x34 reads 0x00000040, the capability pointer.
- R5: Four capabilities are chained in this order:
  - common config at 0x40, type 1, 16 bytes
  - ISR at 0x50, type 3, 16 bytes
  - notify at 0x60, type 2, 20 bytes
  - device config at 0x74, type 4, 16 bytes, with next pointer 0

  Byte 0 of each capability is 0x09, byte 1 is the next pointer, byte 2 is the length and byte 3 is the type. Dword +4 holds the BAR number 0, dword +8 holds the offset into the BAR and dword +12 holds the length. The pairs of offset and length are:
  - common config: 0x000 and 0x40
  - ISR: 0x400 and 0x4
  - notify: 0x800 and 0x400
  - device config: 0xC00 and 0x100

  The notify multiplier at 0x70 reads 4. Dword 0x84 reads 0.
- R6: Read-only words (IDs, pointer, capability bytes) keep their values after a write.
- R7: In the command register, only bit 1 (memory enable) and bit 2 (bus master) are writable. All other command bits read 0.
- R8: BAR0 bits 11:0 always read 0. Writing 0xFFFFFFFF to BAR0 makes the next read of BAR0 return 0xFFFFF000.
- R9: A window access raises `win_hit` in the next cycle, with `win_offset` equal to address bits 11:0, exactly when all of the following hold:
  - the address lies in [BAR0, BAR0+4 KiB)
  - memory enable is set
  - BAR0 is programmed
- R10: There is no window hit while memory enable is clear. There is also no hit when the last BAR0 write was the all-ones sizing value.
- R11: Dword 0x3C reads {16'h0, pin 0x01, line}. The line is writable through byte 0. After reset the line holds IRQ_BASE + ((SLOT + pin − 1) mod 4), which is 33 by default.
- R12: After reset, `cfg_rvalid` and `win_hit` are low, the command register is 0, BAR0 reads 0, and BAR0 counts as unprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration access request |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 28 | ECAM window offset |
| cfg_wdata | input | 32 | Write data (whole dword) |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |
| win_valid | input | 1 | MMIO window access |
| win_addr | input | 32 | MMIO window address |
| win_hit | output | 1 | Access falls inside live BAR0 |
| win_offset | output | 12 | Offset inside BAR0 |

## Verification
The bench walks every capability dword and confirms the exact chain layout. A design that miscounted the 20-byte notify entry would misplace the device-config capability and break the walk.

It targets each field of the ECAM offset in turn: wrong bus, wrong device, wrong function, and device 0. A responder that ignored one of these fields would answer for a phantom device, or would take a write meant for nobody.

The BAR checks cover the sizing write and a reprogram after sizing. They also probe the first and last byte of the window and the bytes just outside it. A decoder that is off by one page, or that keeps hitting after a sizing probe, fails those checks.

Finally, hits are tried with memory decoding off. A design that skipped the enable test would claim bus cycles before software allowed it.

// File: rtl/ecam_pkg.sv
package ecam_pkg;

    localparam int unsigned ECAM_ADDR_W = 28;
    localparam int unsigned NUM_CAPS    = 4;

    localparam logic [15:0] EP_VENDOR    = 16'h1AF4;
    localparam logic [15:0] EP_DEVICE    = 16'h1042;
    localparam logic [31:0] EP_CLASS_REV = 32'h0180_0001;
    localparam logic [31:0] EP_SUBSYS    = 32'h0002_1AF4;
    localparam logic [15:0] EP_STATUS    = 16'h0010;
    localparam logic [7:0]  EP_CAP_PTR   = 8'h40;
    localparam logic [7:0]  CAP_VNDR_ID  = 8'h09;

    // dword indices of the header words with live state
    localparam logic [9:0] IDX_CMD  = 10'd1;
    localparam logic [9:0] IDX_BAR0 = 10'd4;
    localparam logic [9:0] IDX_INTR = 10'd15;

    localparam logic [7:0]  CAP_AT      [NUM_CAPS] = '{8'h40, 8'h50, 8'h60, 8'h74};
    localparam logic [7:0]  CAP_NEXT    [NUM_CAPS] = '{8'h50, 8'h60, 8'h74, 8'h00};
    localparam logic [7:0]  CAP_LEN     [NUM_CAPS] = '{8'd16, 8'd16, 8'd20, 8'd16};
    localparam logic [7:0]  CAP_KIND    [NUM_CAPS] = '{8'd1, 8'd3, 8'd2, 8'd4};
    localparam logic [31:0] CAP_BAR_OFF [NUM_CAPS] = '{32'h000, 32'h400, 32'h800, 32'hC00};
    localparam logic [31:0] CAP_BAR_LEN [NUM_CAPS] = '{32'h040, 32'h004, 32'h400, 32'h100};

    typedef struct packed {
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] reg_off;
    } ecam_addr_t;

endpackage

// File: rtl/ecam_addr_decode.sv
module ecam_addr_decode
    import ecam_pkg::*;
#(
    parameter int unsigned SLOT = 1
) (
    input  logic [ECAM_ADDR_W-1:0] addr,
    output logic                   match,
    output logic [9:0]             dword_idx
);
    ecam_addr_t fields;

    always_comb begin
        fields    = ecam_addr_t'(addr);
        match     = (fields.bus == 8'h00) &&
                    (fields.dev == 5'(SLOT)) &&
                    (fields.fn  == 3'h0);
        dword_idx = fields.reg_off[11:2];
    end
endmodule

// File: rtl/ecam_hdr_rom.sv
module ecam_hdr_rom
    import ecam_pkg::*;
#(
    parameter int unsigned NOTIFY_MULT = 4
) (
    input  logic [9:0]  dword_idx,
    output logic [31:0] word
);
    logic [11:0] byte_at;

    always_comb begin
        byte_at = {dword_idx, 2'b00};
        word    = 32'h0;
        unique case (dword_idx)
            10'd0:   word = {EP_DEVICE, EP_VENDOR};
            10'd2:   word = EP_CLASS_REV;
            10'd11:  word = EP_SUBSYS;
            10'd13:  word = {24'h0, EP_CAP_PTR};
            default: begin
                for (int k = 0; k < NUM_CAPS; k++) begin
                    logic [11:0] rel;
                    rel = byte_at - 12'(CAP_AT[k]);
                    if (byte_at >= 12'(CAP_AT[k]) &&
                        byte_at <  12'(CAP_AT[k]) + 12'(CAP_LEN[k])) begin
                        unique case (rel[4:2])
                            3'd0:    word = {CAP_KIND[k], CAP_LEN[k], CAP_NEXT[k], CAP_VNDR_ID};
                            3'd1:    word = 32'h0;
                            3'd2:    word = CAP_BAR_OFF[k];
                            3'd3:    word = CAP_BAR_LEN[k];
                            3'd4:    word = 32'(NOTIFY_MULT);
                            default: word = 32'h0;
                        endcase
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/ecam_bar_window.sv
module ecam_bar_window #(
    parameter int unsigned BAR_SIZE_LOG2 = 12
) (
    input  logic                     win_valid,
    input  logic [31:0]              win_addr,
    input  logic [31:0]              bar_base,
    input  logic                     bar_live,
    input  logic                     mem_en,
    output logic                     hit,
    output logic [BAR_SIZE_LOG2-1:0] offset
);
    always_comb begin
        hit    = win_valid && mem_en && bar_live &&
                 (win_addr[31:BAR_SIZE_LOG2] == bar_base[31:BAR_SIZE_LOG2]);
        offset = win_addr[BAR_SIZE_LOG2-1:0];
    end
endmodule

// File: rtl/ecam_cfg_responder.sv
module ecam_cfg_responder
    import ecam_pkg::*;
#(
    parameter int unsigned SLOT          = 1,
    parameter int unsigned INTX_PIN      = 1,
    parameter int unsigned IRQ_BASE      = 32,
    parameter int unsigned BAR_SIZE_LOG2 = 12,
    parameter int unsigned NOTIFY_MULT   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_valid,
    input  logic                     cfg_write,
    input  logic [27:0]              cfg_addr,
    input  logic [31:0]              cfg_wdata,
    output logic                     cfg_rvalid,
    output logic [31:0]              cfg_rdata,
    input  logic                     win_valid,
    input  logic [31:0]              win_addr,
    output logic                     win_hit,
    output logic [BAR_SIZE_LOG2-1:0] win_offset
);
    localparam logic [7:0]  LINE_RST = 8'(IRQ_BASE + ((SLOT + INTX_PIN - 1) % 4));
    localparam logic [31:0] BAR_MASK = ~((32'd1 << BAR_SIZE_LOG2) - 32'd1);

    typedef struct packed {
        logic                     cmd_mem;
        logic                     cmd_master;
        logic [31:0]              bar0;
        logic                     bar_live;
        logic [7:0]               int_line;
        logic                     rvalid;
        logic [31:0]              rdata;
        logic                     hit;
        logic [BAR_SIZE_LOG2-1:0] offset;
    } resp_state_t;

    resp_state_t s_d, s_q;

    logic                     tgt_match;
    logic [9:0]               tgt_idx;
    logic [31:0]              rom_word;
    logic [31:0]              live_word;
    logic                     win_hit_c;
    logic [BAR_SIZE_LOG2-1:0] win_off_c;

    ecam_addr_decode #(.SLOT(SLOT)) u_decode (
        .addr      (cfg_addr),
        .match     (tgt_match),
        .dword_idx (tgt_idx)
    );

    ecam_hdr_rom #(.NOTIFY_MULT(NOTIFY_MULT)) u_rom (
        .dword_idx (tgt_idx),
        .word      (rom_word)
    );

    ecam_bar_window #(.BAR_SIZE_LOG2(BAR_SIZE_LOG2)) u_window (
        .win_valid (win_valid),
        .win_addr  (win_addr),
        .bar_base  (s_q.bar0),
        .bar_live  (s_q.bar_live),
        .mem_en    (s_q.cmd_mem),
        .hit       (win_hit_c),
        .offset    (win_off_c)
    );

    always_comb begin
        unique case (tgt_idx)
            IDX_CMD:  live_word = {EP_STATUS, 13'h0, s_q.cmd_master, s_q.cmd_mem, 1'b0};
            IDX_BAR0: live_word = s_q.bar0;
            IDX_INTR: live_word = {16'h0, 8'(INTX_PIN), s_q.int_line};
            default:  live_word = rom_word;
        endcase
    end

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        s_d.rdata  = 32'h0;
        if (cfg_valid && !cfg_write) begin
            s_d.rvalid = 1'b1;
            s_d.rdata  = tgt_match ? live_word : 32'hFFFF_FFFF;
        end
        if (cfg_valid && cfg_write && tgt_match) begin
            unique case (tgt_idx)
                IDX_CMD: begin
                    s_d.cmd_mem    = cfg_wdata[1];
                    s_d.cmd_master = cfg_wdata[2];
                end
                IDX_BAR0: begin
                    s_d.bar0     = cfg_wdata & BAR_MASK;
                    s_d.bar_live = (cfg_wdata != 32'hFFFF_FFFF);
                end
                IDX_INTR: s_d.int_line = cfg_wdata[7:0];
                default:  ;
            endcase
        end
        s_d.hit    = win_hit_c;
        s_d.offset = win_off_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.int_line <= LINE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_rvalid = s_q.rvalid;
    assign cfg_rdata  = s_q.rdata;
    assign win_hit    = s_q.hit;
    assign win_offset = s_q.offset;
endmodule

// File: rtl/ecam_cfg_checker.sv
module ecam_cfg_checker #(
    parameter int unsigned SLOT          = 1,
    parameter int unsigned BAR_SIZE_LOG2 = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_valid,
    input logic        cfg_write,
    input logic [27:0] cfg_addr,
    input logic        cfg_rvalid,
    input logic [31:0] cfg_rdata,
    input logic        win_valid,
    input logic        win_hit,
    input logic        mem_en
);
    localparam logic [15:0] OWN_TGT  = {8'h00, 5'(SLOT), 3'h0};
    localparam logic [31:0] LOW_MASK = (32'd1 << BAR_SIZE_LOG2) - 32'd1;

    logic own_read;
    assign own_read = cfg_valid && !cfg_write && (cfg_addr[27:12] == OWN_TGT);

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_write) |=> cfg_rvalid); // R1
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_write) |=> !cfg_rvalid); // R1
    AST_FOREIGN_BUS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_write && cfg_addr[27:20] != 8'h00) |=> (cfg_rdata == 32'hFFFF_FFFF)); // R1
    AST_IDS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (own_read && cfg_addr[11:2] == 10'd0) |=> (cfg_rdata == 32'h1042_1AF4)); // R3
    AST_BAR_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (own_read && cfg_addr[11:2] == 10'd4) |=> ((cfg_rdata & LOW_MASK) == 32'h0)); // R8
    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> $past(win_valid)); // R9
    AST_HIT_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> $past(mem_en)); // R10
endmodule

bind ecam_cfg_responder ecam_cfg_checker #(
    .SLOT          (SLOT),
    .BAR_SIZE_LOG2 (BAR_SIZE_LOG2)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_write  (cfg_write),
    .cfg_addr   (cfg_addr),
    .cfg_rvalid (cfg_rvalid),
    .cfg_rdata  (cfg_rdata),
    .win_valid  (win_valid),
    .win_hit    (win_hit),
    .mem_en     (s_q.cmd_mem)
);

// File: tb/ecam_cfg_responder_bench.sv
`timescale 1ns/1ps
module ecam_cfg_responder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        cfg_write = 1'b0;
    logic [27:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic        win_valid = 1'b0;
    logic [31:0] win_addr = '0;
    logic        win_hit;
    logic [11:0] win_offset;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    ecam_cfg_responder u_ecam_cfg_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_write  (cfg_write),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rvalid (cfg_rvalid),
        .cfg_rdata  (cfg_rdata),
        .win_valid  (win_valid),
        .win_addr   (win_addr),
        .win_hit    (win_hit),
        .win_offset (win_offset)
    );

    typedef struct packed {
        logic        wr;
        logic [27:0] addr;
        logic [31:0] data;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 48;
    // own target: bus 0, device 1, function 0 -> base 0x0008000
    localparam vec_t VEC [NV] = '{
        '{1'b0, 28'h0008000, 32'h0, 32'h1042_1AF4, 4'd3},  // R3 ids
        '{1'b0, 28'h0008004, 32'h0, 32'h0010_0000, 4'd12}, // R12 command after reset, R4 status
        '{1'b0, 28'h0008008, 32'h0, 32'h0180_0001, 4'd3},  // R3
        '{1'b0, 28'h000800C, 32'h0, 32'h0000_0000, 4'd3},  // R3 header type
        '{1'b0, 28'h0008010, 32'h0, 32'h0000_0000, 4'd12}, // R12 BAR after reset
        '{1'b0, 28'h000802C, 32'h0, 32'h0002_1AF4, 4'd3},  // R3 subsystem
        '{1'b0, 28'h0008034, 32'h0, 32'h0000_0040, 4'd4},  // R4 cap pointer
        '{1'b0, 28'h000803C, 32'h0, 32'h0000_0121, 4'd11}, // R11 pin 1, line 33
        '{1'b0, 28'h0008040, 32'h0, 32'h0110_5009, 4'd5},  // R5 common
        '{1'b0, 28'h0008044, 32'h0, 32'h0000_0000, 4'd5},
        '{1'b0, 28'h0008048, 32'h0, 32'h0000_0000, 4'd5},
        '{1'b0, 28'h000804C, 32'h0, 32'h0000_0040, 4'd5},
        '{1'b0, 28'h0008050, 32'h0, 32'h0310_6009, 4'd5},  // R5 ISR
        '{1'b0, 28'h0008054, 32'h0, 32'h0000_0000, 4'd5},
        '{1'b0, 28'h0008058, 32'h0, 32'h0000_0400, 4'd5},
        '{1'b0, 28'h000805C, 32'h0, 32'h0000_0004, 4'd5},
        '{1'b0, 28'h0008060, 32'h0, 32'h0214_7409, 4'd5},  // R5 notify
        '{1'b0, 28'h0008064, 32'h0, 32'h0000_0000, 4'd5},
        '{1'b0, 28'h0008068, 32'h0, 32'h0000_0800, 4'd5},
        '{1'b0, 28'h000806C, 32'h0, 32'h0000_0400, 4'd5},
        '{1'b0, 28'h0008070, 32'h0, 32'h0000_0004, 4'd5},
        '{1'b0, 28'h0008074, 32'h0, 32'h0410_0009, 4'd5},  // R5 device config
        '{1'b0, 28'h0008078, 32'h0, 32'h0000_0000, 4'd5},
        '{1'b0, 28'h000807C, 32'h0, 32'h0000_0C00, 4'd5},
        '{1'b0, 28'h0008080, 32'h0, 32'h0000_0100, 4'd5},
        '{1'b0, 28'h0008084, 32'h0, 32'h0000_0000, 4'd5},
        '{1'b1, 28'h0008000, 32'hFFFF_FFFF, 32'h0, 4'd6},  // R6 read-only writes
        '{1'b0, 28'h0008000, 32'h0, 32'h1042_1AF4, 4'd6},
        '{1'b1, 28'h0008034, 32'h0, 32'h0, 4'd6},
        '{1'b0, 28'h0008034, 32'h0, 32'h0000_0040, 4'd6},
        '{1'b1, 28'h0008040, 32'h0, 32'h0, 4'd6},
        '{1'b0, 28'h0008040, 32'h0, 32'h0110_5009, 4'd6},
        '{1'b1, 28'h0008004, 32'hFFFF_FFFF, 32'h0, 4'd7},  // R7 command mask
        '{1'b0, 28'h0008004, 32'h0, 32'h0010_0006, 4'd7},
        '{1'b1, 28'h0008004, 32'h0, 32'h0, 4'd7},
        '{1'b0, 28'h0008004, 32'h0, 32'h0010_0000, 4'd7},
        '{1'b1, 28'h0008010, 32'hFFFF_FFFF, 32'h0, 4'd8},  // R8 sizing
        '{1'b0, 28'h0008010, 32'h0, 32'hFFFF_F000, 4'd8},
        '{1'b1, 28'h0008010, 32'h1234_5678, 32'h0, 4'd8},
        '{1'b0, 28'h0008010, 32'h0, 32'h1234_5000, 4'd8},
        '{1'b1, 28'h000803C, 32'h0000_00AB, 32'h0, 4'd11}, // R11 line writable
        '{1'b0, 28'h000803C, 32'h0, 32'h0000_01AB, 4'd11},
        '{1'b0, 28'h0108000, 32'h0, 32'hFFFF_FFFF, 4'd1},  // R1 bus 1
        '{1'b0, 28'h0010000, 32'h0, 32'hFFFF_FFFF, 4'd1},  // R1 device 2
        '{1'b0, 28'h0009000, 32'h0, 32'hFFFF_FFFF, 4'd1},  // R1 function 1
        '{1'b0, 28'h0000000, 32'h0, 32'hFFFF_FFFF, 4'd1},  // R1 device 0
        '{1'b1, 28'h0108010, 32'hABCD_E000, 32'h0, 4'd2},  // R2 foreign BAR write
        '{1'b0, 28'h0008010, 32'h0, 32'h1234_5000, 4'd2}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
        end
    endtask

    task automatic cfg_op(input logic wr, input logic [27:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_write = wr;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_write = 1'b0;
    endtask

    task automatic win_op(input logic v, input logic [31:0] a, input logic eh,
                          input logic [11:0] eo, input string tag);
        @(negedge clk);
        win_valid = v;
        win_addr  = a;
        @(negedge clk);
        win_valid = 1'b0;
        check({tag, " hit"}, 32'(win_hit), 32'(eh));
        if (eh) check({tag, " offset"}, 32'(win_offset), 32'(eo));
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 rvalid after reset", 32'(cfg_rvalid), 32'd0);
        check("R12 win_hit after reset", 32'(win_hit), 32'd0);

        // R12: BAR unprogrammed after reset, so even base 0 with mem enable misses
        cfg_op(1'b1, 28'h0008004, 32'h0000_0002);
        win_op(1'b1, 32'h0000_0010, 1'b0, 12'h0, "R12 unprogrammed BAR");
        cfg_op(1'b1, 28'h0008004, 32'h0000_0000);

        for (int i = 0; i < NV; i++) begin
            cfg_op(VEC[i].wr, VEC[i].addr, VEC[i].data);
            if (VEC[i].wr) begin
                check($sformatf("R%0d write no rvalid (R1) row %0d", VEC[i].req, i),
                      32'(cfg_rvalid), 32'd0);
            end else begin
                check($sformatf("R%0d rvalid row %0d", VEC[i].req, i), 32'(cfg_rvalid), 32'd1);
                check($sformatf("R%0d rdata row %0d", VEC[i].req, i), cfg_rdata, VEC[i].expv);
            end
        end

        // R2: foreign command write, then own command still clear
        cfg_op(1'b1, 28'h0010004, 32'hFFFF_FFFF);
        cfg_op(1'b0, 28'h0008004, 32'h0);
        check("R2 foreign command write", cfg_rdata, 32'h0010_0000);

        // R10: memory enable off
        win_op(1'b1, 32'h1234_5010, 1'b0, 12'h0, "R10 mem disabled");
        cfg_op(1'b1, 28'h0008004, 32'h0000_0002);
        win_op(1'b1, 32'h1234_5010, 1'b1, 12'h010, "R9 inside");
        win_op(1'b1, 32'h1234_5000, 1'b1, 12'h000, "R9 first byte");
        win_op(1'b1, 32'h1234_5FFC, 1'b1, 12'hFFC, "R9 last dword");
        win_op(1'b1, 32'h1234_6000, 1'b0, 12'h0, "R9 just above");
        win_op(1'b1, 32'h1234_4FFC, 1'b0, 12'h0, "R9 just below");
        win_op(1'b0, 32'h1234_5010, 1'b0, 12'h0, "R9 no request");

        // R10: sizing write leaves the BAR unprogrammed
        cfg_op(1'b1, 28'h0008010, 32'hFFFF_FFFF);
        win_op(1'b1, 32'hFFFF_F004, 1'b0, 12'h0, "R10 after sizing");
        cfg_op(1'b1, 28'h0008010, 32'h8000_0000);
        win_op(1'b1, 32'h8000_0000, 1'b1, 12'h000, "R9 reprogrammed");
        win_op(1'b1, 32'h8000_0ABC, 1'b1, 12'hABC, "R9 reprogrammed offset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule